// File: doc/BRIEF.md
# Prescaled Cascadable Reload Timer Bank

The block holds a bank of 8-bit down-counting timers. Each timer has a reload value, a run bit and a count-source choice. The source is either one tap of a free-running prescaler that every timer shares, or the underflow event of the timer one position below it, which lets timers be chained into wider counters. Software reaches every timer through a small synchronous register bus with a write strobe, an address and write data. Read data is combinational from the address.

When a timer counts down past zero it reloads from its latch. It also raises a sticky interrupt flag and gives a one-cycle underflow pulse. The shared prescaler runs from reset and is never restarted when a timer starts. For that reason, the first decrement on a divided source can lag the start by up to one period of the chosen tap. The divided clocks stay inside the block.

Each timer owns four address slots. Address bits [ADDR_W-1:2] select the timer and bits [1:0] select the register: 0 is the count register, 1 is control, 2 is the flag and 3 reads as zero. The control byte holds the run bit in bit 0, the cascade select in bit 1 and the prescaler tap select in bits [4:2].

Top module: `tmr_bank`

## Requirements
- R1: After a synchronous reset, every counter, reload latch, control byte, interrupt flag and underflow pulse is zero, and the prescaler restarts at zero.
- R2: A write to a stopped timer's count register (offset 0) loads both the reload latch and the counter. A stopped timer's counter never changes otherwise.
- R3: With cascade clear, a running timer decrements once per prescaler tick. Tap select values 0 to 7 pick divide-by 1, 2, 8, 16, 32, 64, 128 and 256. Divide-by-2^k ticks in the cycles where the low k bits of the free-running prescaler are all ones, and starting a timer does not touch the prescaler.
- R4: A count enable that arrives while the counter is zero is an underflow. The counter reloads from the latch, the flag sets, and `uf_o` for that timer is high for exactly the following cycle.
- R5: The flag stays set until a write to offset 2 with data bit 0 set clears it. Writing 0 there has no effect, and a new underflow in the same cycle wins over the clear.
- R6: A write to the count register of a running timer updates only the reload latch, and the counter holds its value in that cycle instead of counting.
- R7: If that write lands in the cycle of an underflow, the written value goes into both the counter and the latch, and the flag and pulse still occur.
- R8: With cascade set (control bit 1), timer n counts once in each cycle in which timer n-1 underflows, in the same cycle. Timer 0 in cascade never counts.
- R9: While a timer runs, writes to its control register change only the run bit. The cascade and tap fields take new values only when the timer is stopped at the time of the write.
- R10: Reading offset 1 returns {3'b0, tap, cascade, run}, reading offset 2 returns {7'b0, flag}, and reading offset 0 returns the live counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (4) | Timer index in the upper bits, register offset in bits [1:0] |
| bus_wdata | input | CNT_W (8) | Write data |
| bus_rdata | output | CNT_W (8) | Read data for the addressed register |
| irq_o | output | N_TMR (4) | Sticky underflow flags, one per timer |
| uf_o | output | N_TMR (4) | One-cycle underflow pulses, one per timer |

## Verification
A reload-latch write and an underflow can land on the same clock edge. In that case the written value must go into both the latch and the counter, while the flag and pulse still appear. The bench runs a timer on the undivided source and watches its count register. It issues the latch write on the exact cycle the read shows zero, so the write lands on the underflow edge. A second write at a non-zero count shows the counter holding instead. A behavioural model that updates every cycle judges the counter, flags and pulses after each edge.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;

    localparam int TAP_CNT   = 8;
    localparam int TAP_SEL_W = 3;
    localparam int REG_OFS_W = 2;

    localparam logic [REG_OFS_W-1:0] REG_COUNT = 2'd0;
    localparam logic [REG_OFS_W-1:0] REG_CTRL  = 2'd1;
    localparam logic [REG_OFS_W-1:0] REG_FLAG  = 2'd2;

    typedef struct packed {
        logic [TAP_SEL_W-1:0] tap;
        logic                 casc;
        logic                 run;
    } tmr_ctrl_t;

    localparam int CTRL_W = $bits(tmr_ctrl_t);

    // log2 of the division ratio chosen by a tap select value
    function automatic int tap_log2(input int sel);
        case (sel)
            0:       return 0;
            1:       return 1;
            2:       return 3;
            3:       return 4;
            4:       return 5;
            5:       return 6;
            6:       return 7;
            7:       return 8;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_bank_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    output logic [TAP_CNT-1:0] tick_o
);

    logic [DIV_W-1:0] div_q;

    // free running; only the system reset restarts it
    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    for (genvar t = 0; t < TAP_CNT; t++) begin : g_tap
        localparam int K = tap_log2(t);
        if (K == 0) begin : g_full
            assign tick_o[t] = 1'b1;
        end else begin : g_div
            assign tick_o[t] = &div_q[K-1:0];
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_bank_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [TAP_CNT-1:0] tick_i,
    input  logic               casc_i,
    input  logic               wr_count_i,
    input  logic               wr_ctrl_i,
    input  logic               wr_flag_i,
    input  logic [CNT_W-1:0]   wdata_i,
    output logic [CNT_W-1:0]   cnt_o,
    output tmr_ctrl_t          ctrl_o,
    output logic               flag_o,
    output logic               en_o,
    output logic               evt_o,
    output logic               uf_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] latch_q;
    tmr_ctrl_t        ctrl_q;
    tmr_ctrl_t        ctrl_nxt;
    logic             flag_q;
    logic             uf_q;
    logic             en;
    logic             evt;

    assign en  = ctrl_q.run & (ctrl_q.casc ? casc_i : tick_i[ctrl_q.tap]);
    assign evt = en & (cnt_q == '0);

    // source fields are frozen while running
    always_comb begin
        ctrl_nxt = tmr_ctrl_t'(wdata_i[CTRL_W-1:0]);
        if (ctrl_q.run) begin
            ctrl_nxt.tap  = ctrl_q.tap;
            ctrl_nxt.casc = ctrl_q.casc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            latch_q <= '0;
            ctrl_q  <= '0;
            flag_q  <= 1'b0;
            uf_q    <= 1'b0;
        end else begin
            uf_q <= evt;
            if (wr_count_i) latch_q <= wdata_i;
            if (evt) begin
                cnt_q <= wr_count_i ? wdata_i : latch_q;
            end else if (wr_count_i) begin
                if (!ctrl_q.run) cnt_q <= wdata_i;
            end else if (en) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (wr_ctrl_i) ctrl_q <= ctrl_nxt;
            if (evt)                         flag_q <= 1'b1;
            else if (wr_flag_i && wdata_i[0]) flag_q <= 1'b0;
        end
    end

    assign cnt_o  = cnt_q;
    assign ctrl_o = ctrl_q;
    assign flag_o = flag_q;
    assign en_o   = en;
    assign evt_o  = evt;
    assign uf_o   = uf_q;

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_bank_pkg::*;
#(
    parameter int N_TMR = 4,
    parameter int CNT_W = 8,
    parameter int DIV_W = 8,
    localparam int IDX_W  = (N_TMR > 1) ? $clog2(N_TMR) : 1,
    localparam int ADDR_W = IDX_W + REG_OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [N_TMR-1:0]  irq_o,
    output logic [N_TMR-1:0]  uf_o
);

    logic [TAP_CNT-1:0]                tick;
    logic [N_TMR-1:0][CNT_W-1:0]       cnt_vec;
    logic [N_TMR-1:0][TAP_SEL_W-1:0]   tap_vec;
    logic [N_TMR-1:0]                  run_vec;
    logic [N_TMR-1:0]                  casc_vec;
    logic [N_TMR-1:0]                  en_vec;
    logic [N_TMR-1:0]                  evt_vec;
    logic [N_TMR-1:0]                  flag_vec;
    tmr_ctrl_t                         ctrl_arr [N_TMR];
    logic [IDX_W-1:0]                  sel_idx;
    logic [REG_OFS_W-1:0]              sel_ofs;

    assign sel_idx = bus_addr[ADDR_W-1:REG_OFS_W];
    assign sel_ofs = bus_addr[REG_OFS_W-1:0];

    tmr_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    for (genvar i = 0; i < N_TMR; i++) begin : g_ch
        logic casc_l;
        logic evt_l;
        logic hit;

        assign hit = bus_we && (sel_idx == IDX_W'(i));

        if (i == 0) begin : g_head
            assign casc_l = 1'b0;
        end else begin : g_link
            assign casc_l = g_ch[i-1].evt_l;
        end

        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .tick_i     (tick),
            .casc_i     (casc_l),
            .wr_count_i (hit && (sel_ofs == REG_COUNT)),
            .wr_ctrl_i  (hit && (sel_ofs == REG_CTRL)),
            .wr_flag_i  (hit && (sel_ofs == REG_FLAG)),
            .wdata_i    (bus_wdata),
            .cnt_o      (cnt_vec[i]),
            .ctrl_o     (ctrl_arr[i]),
            .flag_o     (flag_vec[i]),
            .en_o       (en_vec[i]),
            .evt_o      (evt_l),
            .uf_o       (uf_o[i])
        );

        assign evt_vec[i]  = evt_l;
        assign run_vec[i]  = ctrl_arr[i].run;
        assign casc_vec[i] = ctrl_arr[i].casc;
        assign tap_vec[i]  = ctrl_arr[i].tap;
    end

    always_comb begin
        bus_rdata = '0;
        if (int'(sel_idx) < N_TMR) begin
            case (sel_ofs)
                REG_COUNT: bus_rdata = cnt_vec[sel_idx];
                REG_CTRL:  bus_rdata = CNT_W'(ctrl_arr[sel_idx]);
                REG_FLAG:  bus_rdata = CNT_W'(flag_vec[sel_idx]);
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign irq_o = flag_vec;

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
    parameter int N_TMR  = 4,
    parameter int CNT_W  = 8,
    parameter int IDX_W  = 2,
    parameter int ADDR_W = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      bus_we,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic                      wbit0,
    input logic [N_TMR-1:0]          irq,
    input logic [N_TMR-1:0]          uf,
    input logic [N_TMR-1:0]          run_vec,
    input logic [N_TMR-1:0]          casc_vec,
    input logic [N_TMR-1:0][2:0]     tap_vec,
    input logic [N_TMR-1:0][CNT_W-1:0] cnt_vec,
    input logic [N_TMR-1:0]          en_vec,
    input logic [N_TMR-1:0]          evt_vec
);

    for (genvar i = 0; i < N_TMR; i++) begin : g_c
        logic wr_cnt;
        logic wr_clr;
        assign wr_cnt = bus_we && (bus_addr == ADDR_W'(i * 4));
        assign wr_clr = bus_we && (bus_addr == ADDR_W'(i * 4 + 2)) && wbit0;

        p_stop_hold_r2: assert property (@(posedge clk) disable iff (rst)
            (!run_vec[i] && !wr_cnt) |=> $stable(cnt_vec[i]));

        p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
            (en_vec[i] && !evt_vec[i] && !wr_cnt) |=> (cnt_vec[i] == $past(cnt_vec[i]) - CNT_W'(1)));

        p_uf_pulse_r4: assert property (@(posedge clk) disable iff (rst)
            evt_vec[i] |=> (uf[i] && irq[i]));

        p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
            (irq[i] && !wr_clr) |=> irq[i]);

        p_write_hold_r6: assert property (@(posedge clk) disable iff (rst)
            (wr_cnt && run_vec[i] && !evt_vec[i]) |=> $stable(cnt_vec[i]));

        p_src_freeze_r9: assert property (@(posedge clk) disable iff (rst)
            run_vec[i] |=> ($stable(tap_vec[i]) && $stable(casc_vec[i])));

        if (i > 0) begin : g_casc
            p_cascade_r8: assert property (@(posedge clk) disable iff (rst)
                (run_vec[i] && casc_vec[i]) |-> (en_vec[i] == evt_vec[i-1]));
        end else begin : g_head
            p_head_idle_r8: assert property (@(posedge clk) disable iff (rst)
                casc_vec[i] |-> !en_vec[i]);
        end
    end

endmodule

bind tmr_bank tmr_bank_chk #(
    .N_TMR  (N_TMR),
    .CNT_W  (CNT_W),
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .wbit0    (bus_wdata[0]),
    .irq      (irq_o),
    .uf       (uf_o),
    .run_vec  (run_vec),
    .casc_vec (casc_vec),
    .tap_vec  (tap_vec),
    .cnt_vec  (cnt_vec),
    .en_vec   (en_vec),
    .evt_vec  (evt_vec)
);

// File: tb/tmr_bank_tb.sv
`timescale 1ns/1ps
module tmr_bank_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] irq_o;
    logic [3:0] uf_o;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_cnt [4];
    int m_lat [4];
    int m_run [4];
    int m_cas [4];
    int m_tap [4];
    int m_flag[4];
    int m_uf  [4];
    int m_evt [4];
    int m_en  [4];
    int m_div;

    tmr_bank u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .uf_o      (uf_o)
    );

    always #10 clk = ~clk;

    function automatic int ratio_log(input int sel);
        int tbl[8] = '{0, 1, 3, 4, 5, 6, 7, 8};
        return tbl[sel];
    endfunction

    function automatic bit tap_fires(input int sel, input int dv);
        int p;
        p = 1 << ratio_log(sel);
        return (dv % p) == (p - 1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin
                m_cnt[i] = 0; m_lat[i] = 0; m_run[i] = 0; m_cas[i] = 0;
                m_tap[i] = 0; m_flag[i] = 0; m_uf[i] = 0;
            end
            m_div = 0;
        end else begin
            for (int i = 0; i < 4; i++) begin
                if (m_cas[i] != 0) m_en[i] = (m_run[i] != 0 && i > 0 && m_evt[i-1] != 0) ? 1 : 0;
                else               m_en[i] = (m_run[i] != 0 && tap_fires(m_tap[i], m_div)) ? 1 : 0;
                m_evt[i] = (m_en[i] != 0 && m_cnt[i] == 0) ? 1 : 0;
            end
            for (int i = 0; i < 4; i++) begin
                bit wc, wk, wf;
                wc = bus_we && (int'(bus_addr) == i * 4);
                wk = bus_we && (int'(bus_addr) == i * 4 + 1);
                wf = bus_we && (int'(bus_addr) == i * 4 + 2);
                if (m_evt[i] != 0) begin
                    m_cnt[i] = wc ? int'(bus_wdata) : m_lat[i];
                end else if (wc) begin
                    if (m_run[i] == 0) m_cnt[i] = int'(bus_wdata);
                end else if (m_en[i] != 0) begin
                    m_cnt[i] = m_cnt[i] - 1;
                end
                if (wc) m_lat[i] = int'(bus_wdata);
                if (m_evt[i] != 0) m_flag[i] = 1;
                else if (wf && bus_wdata[0]) m_flag[i] = 0;
                m_uf[i] = m_evt[i];
                if (wk) begin
                    if (m_run[i] == 0) begin
                        m_cas[i] = int'(bus_wdata[1]);
                        m_tap[i] = int'(bus_wdata[4:2]);
                    end
                    m_run[i] = int'(bus_wdata[0]);
                end
            end
            m_div = (m_div + 1) % 256;
        end
    end

    function automatic logic [7:0] exp_rd();
        int t, r;
        t = int'(bus_addr) / 4;
        r = int'(bus_addr) % 4;
        case (r)
            0: return 8'(m_cnt[t]);
            1: return 8'((m_tap[t] << 2) | (m_cas[t] << 1) | m_run[t]);
            2: return 8'(m_flag[t]);
            default: return 8'h00;
        endcase
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    // compare after every edge, before the next input change
    always @(posedge clk) begin
        logic [3:0] ei, eu;
        logic [7:0] er;
        #5;
        for (int i = 0; i < 4; i++) begin
            ei[i] = (m_flag[i] != 0);
            eu[i] = (m_uf[i] != 0);
        end
        er = exp_rd();
        vectors++;
        if (bus_rdata !== er || irq_o !== ei || uf_o !== eu) begin
            errors++;
            $display("FAIL %s t=%0t addr=%0d rdata=%h exp %h irq=%b exp %b uf=%b exp %b",
                     cur_req, $time, bus_addr, bus_rdata, er, irq_o, ei, uf_o, eu);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            errors++;
            $display("FAIL watchdog %s expired, actual %0d cycles expected fewer", cur_req, cyc);
            finish_run();
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = 8'(d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic watch(input int a, input int n);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 4'(a);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state on every register
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < 16; a++) watch(a, 1);

        // R2: load while stopped, counter holds
        cur_req = "R2";
        wr(0, 5);
        watch(0, 8);

        // R3 R4: undivided source, underflow reload, flag and pulse
        cur_req = "R3 R4";
        wr(1, 8'h01);
        watch(0, 20);

        // R5: stop, then flag stays on a zero write, clears on a one
        cur_req = "R5";
        wr(1, 8'h00);
        watch(2, 3);
        wr(2, 0);
        watch(2, 3);
        wr(2, 1);
        watch(2, 3);

        // R3: divide-by-8 tap on timer 1
        cur_req = "R3 tap";
        wr(4, 3);
        wr(5, (2 << 2) | 1);
        watch(4, 70);

        // R8: timer 2 chained on timer 1, timer 0 chained on nothing
        cur_req = "R8";
        wr(8, 2);
        wr(9, 8'h03);
        watch(8, 120);
        wr(0, 4);
        wr(1, 8'h03);
        watch(0, 30);

        // R9: source fields ignored while running, taken when stopped
        cur_req = "R9";
        wr(5, (7 << 2) | 1);
        watch(5, 3);
        watch(4, 40);
        wr(5, 0);
        watch(5, 2);
        wr(5, (5 << 2) | 1);
        watch(5, 2);

        // R10: read map of control and flag
        cur_req = "R10";
        for (int a = 0; a < 16; a++) watch(a, 1);

        // R6: latch-only write at a non-zero count
        cur_req = "R6";
        wr(12, 40);
        wr(13, 8'h01);
        watch(12, 3);
        wr(12, 9);
        watch(12, 50);

        // R7: latch write on the underflow edge
        cur_req = "R7";
        watch(12, 1);
        for (int k = 0; k < 80; k++) begin
            if (bus_rdata == 8'h00) break;
            @(negedge clk);
        end
        bus_we = 1'b1; bus_addr = 4'd12; bus_wdata = 8'd77;
        @(negedge clk);
        bus_we = 1'b0;
        watch(12, 100);
        watch(14, 2);

        finish_run();
    end

endmodule